// File: doc/BRIEF.md
# SMBus Converter Command Receiver with Broadcast Update

This block is the serial front end of a 10-bit converter. It watches an SMBus clock and data pair that have already been synchronised to the system clock. It finds START and STOP conditions and shifts bytes in on rising SCL. It acknowledges a byte by pulling SDA low through an open-drain enable. Writes to its own 7-bit address are command/data transactions. The command byte arrives first. A full transaction then carries a low data byte and a high data byte. A shortened transaction ends after the command byte and carries no data.

Three storage elements make up the register state: an input register, an output latch that drives `dac_code`, and a stored synchronise flag (SY) taken from the last accepted command byte. When SY is clear, a completed data write reaches the output latch at once. When SY is set, the data waits in the input register. It moves to the output latch when a Quick Command to the shared broadcast address carries a 1. A Quick Command carrying a 0 wipes all three elements. Several converters can therefore share one broadcast address and commit or clear together.

The controller is one state machine:
- `ST_IDLE` waits for START.
- `ST_ADDR` shifts the address byte.
- `ST_ADDR_ACK` acknowledges the block's own write address.
- `ST_CMD` and `ST_CMD_ACK` receive and accept the command byte.
- `ST_LO`, `ST_LO_ACK`, `ST_HI` and `ST_HI_ACK` take the two data bytes.
- `ST_SYNC_ACK` acknowledges the broadcast address and applies its bit.
- `ST_WAIT` keeps SDA released until the next START or STOP.

The transitions are as follows:
- START from any state leads to `ST_ADDR`.
- STOP from any state leads to `ST_IDLE`.
- After eight bits in `ST_ADDR`, the next falling SCL picks the next state. An own-address write goes to `ST_ADDR_ACK`. The broadcast address goes to `ST_SYNC_ACK`. Anything else goes to `ST_WAIT`.
- Each byte state moves to its ACK state on the falling SCL after its eighth bit.
- Each ACK state moves on at the falling SCL that ends its ACK clock: `ST_ADDR_ACK` to `ST_CMD`, `ST_CMD_ACK` to `ST_LO`, `ST_LO_ACK` to `ST_HI`, and both `ST_HI_ACK` and `ST_SYNC_ACK` to `ST_WAIT`.

Top module: `smb_dac_rx`

## Requirements
- R1: A START seen in any state (SDA falling while SCL is high) begins a new address byte. A STOP (SDA rising while SCL is high) returns the block to idle with SDA released.
- R2: The block acknowledges a write (R/W bit, the eighth bit after START, equal to 0) to its own address DEV_ADDR (default 7'h20) and the broadcast address 7'b1111110. It does not acknowledge other addresses or reads to its own address. After such an address it acknowledges nothing until the next START.
- R3: `sda_oe` is high from the SCL falling edge that ends the eighth bit of an acknowledged byte until the SCL falling edge that ends the ninth clock. It is low at every other time.
- R4: The command byte is accepted on the rising SCL of its ACK clock. Bit 7 of the command byte becomes the stored SY flag, and every other command bit is ignored.
- R5: In a full write the low data byte (D7..D0, MSB first) comes before the high data byte. In the high byte, bit 1 carries D9 and bit 0 carries D8, and bits 7:2 are ignored. The 10-bit word enters the input register on the rising SCL of the high byte's ACK clock.
- R6: If the stored SY flag is 0 when the word is written, the output latch (`dac_code`) takes the same word at the same moment.
- R7: If the stored SY flag is 1, a data write leaves `dac_code` unchanged.
- R8: A START or STOP after the command byte has been accepted but before the high byte's ACK throws away both data bytes and keeps the new command (including its SY flag).
- R9: A START or STOP before the command byte's ACK throws away the partial command and changes no stored state.
- R10: A Quick Command to 7'b1111110 whose single bit is 1, with SY = 1, copies the input register into the output latch on the rising SCL of its ACK clock.
- R11: A Quick Command to 7'b1111110 whose bit is 1 has no effect when SY = 0.
- R12: A Quick Command to 7'b1111110 whose bit is 0 clears the input register, the output latch and the SY flag, whatever SY holds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Synchronised SMBus clock |
| sda_i | input | 1 | Synchronised SMBus data (bus level) |
| sda_oe | output | 1 | 1 pulls SDA low (open-drain enable) |
| dac_code | output | 10 | Output latch value sent to the converter |

## Verification
An SCL edge in the inputs is seen in the same clock, and `sda_oe` follows it one clock later because it is decoded from the state register. The register file, and so `dac_code`, changes one clock after the rising SCL of the relevant ACK clock. The bench drives every bus phase for three system clocks and samples on the falling system-clock edge. The acknowledge is checked two phases after the falling SCL that opens the ACK slot, and again one phase after the falling SCL that closes it. `dac_code` is checked only after the transaction's STOP, well past the single-clock latency.

// File: rtl/smb_dac_pkg.sv
package smb_dac_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_CMD,
        ST_CMD_ACK,
        ST_LO,
        ST_LO_ACK,
        ST_HI,
        ST_HI_ACK,
        ST_SYNC_ACK,
        ST_WAIT
    } smb_state_e;

    typedef struct packed {
        logic start;
        logic stop;
        logic rise;
        logic fall;
    } bus_evt_t;

endpackage

// File: rtl/smb_line_mon.sv
module smb_line_mon
    import smb_dac_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     scl_i,
    input  logic     sda_i,
    output bus_evt_t evt
);

    logic scl_q;
    logic sda_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_i;
            sda_q <= sda_i;
        end
    end

    always_comb begin
        evt.rise  = scl_i & ~scl_q;
        evt.fall  = ~scl_i & scl_q;
        evt.start = scl_i & scl_q & sda_q & ~sda_i;
        evt.stop  = scl_i & scl_q & ~sda_q & sda_i;
    end

endmodule

// File: rtl/smb_dac_regs.sv
module smb_dac_regs #(
    parameter int DATA_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_we,
    input  logic              cmd_sy,
    input  logic              word_we,
    input  logic [DATA_W-1:0] word,
    input  logic              sync_load,
    input  logic              sync_clear,
    output logic [DATA_W-1:0] out_q
);

    logic [DATA_W-1:0] in_q;
    logic              sy_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            in_q  <= '0;
            out_q <= '0;
            sy_q  <= 1'b0;
        end else if (sync_clear) begin
            in_q  <= '0;
            out_q <= '0;
            sy_q  <= 1'b0;
        end else begin
            if (cmd_we) begin
                sy_q <= cmd_sy;
            end
            if (word_we) begin
                in_q <= word;
                if (!sy_q) begin
                    out_q <= word;
                end
            end
            if (sync_load && sy_q) begin
                out_q <= in_q;
            end
        end
    end

    // R12: broadcast clear empties every element
    a_r12_clear_all: assert property (@(posedge clk) disable iff (!rst_n)
        sync_clear |=> (out_q == '0 && in_q == '0 && !sy_q));

    // R6: direct write when SY is clear
    a_r6_direct_write: assert property (@(posedge clk) disable iff (!rst_n)
        (word_we && !sy_q && !sync_clear) |=> out_q == $past(word));

    // R7: output held on a write when SY is set
    a_r7_hold_on_sy: assert property (@(posedge clk) disable iff (!rst_n)
        (word_we && sy_q && !sync_load && !sync_clear) |=> $stable(out_q));

    // R11: broadcast load ignored when SY is clear
    a_r11_sync_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_load && !sy_q && !word_we && !sync_clear) |=> $stable(out_q));

endmodule

// File: rtl/smb_dac_rx.sv
module smb_dac_rx
    import smb_dac_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR  = 7'h20,
    parameter logic [6:0] SYNC_ADDR = 7'b1111110,
    parameter int         DATA_W    = 10,
    parameter int         BYTE_W    = 8,
    parameter int         SY_BIT    = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe,
    output logic [DATA_W-1:0] dac_code
);

    localparam int HI_W  = DATA_W - BYTE_W;
    localparam int CNT_W = $clog2(BYTE_W + 1);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W);

    bus_evt_t           ev;
    smb_state_e         state;
    smb_state_e         state_n;
    logic [BYTE_W-1:0]  shreg;
    logic [CNT_W-1:0]   bit_cnt;
    logic [BYTE_W-1:0]  lo_q;
    logic               sync_bit_q;
    logic               byte_done;
    logic               in_byte;
    logic               cmd_we;
    logic               word_we;
    logic               sync_load;
    logic               sync_clear;
    logic [DATA_W-1:0]  word;

    smb_line_mon u_mon (
        .clk   (clk),
        .rst_n (rst_n),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .evt   (ev)
    );

    assign byte_done = (bit_cnt == LAST_BIT);
    assign in_byte   = (state == ST_ADDR) || (state == ST_CMD) ||
                       (state == ST_LO)   || (state == ST_HI);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_n;
        end
    end

    // next state
    always_comb begin
        state_n = state;
        if (ev.stop) begin
            state_n = ST_IDLE;
        end else if (ev.start) begin
            state_n = ST_ADDR;
        end else begin
            unique case (state)
                ST_IDLE, ST_WAIT: state_n = state;
                ST_ADDR: begin
                    if (ev.fall && byte_done) begin
                        if (shreg[7:1] == DEV_ADDR && !shreg[0]) begin
                            state_n = ST_ADDR_ACK;
                        end else if (shreg[7:1] == SYNC_ADDR) begin
                            state_n = ST_SYNC_ACK;
                        end else begin
                            state_n = ST_WAIT;
                        end
                    end
                end
                ST_ADDR_ACK: if (ev.fall) state_n = ST_CMD;
                ST_CMD:      if (ev.fall && byte_done) state_n = ST_CMD_ACK;
                ST_CMD_ACK:  if (ev.fall) state_n = ST_LO;
                ST_LO:       if (ev.fall && byte_done) state_n = ST_LO_ACK;
                ST_LO_ACK:   if (ev.fall) state_n = ST_HI;
                ST_HI:       if (ev.fall && byte_done) state_n = ST_HI_ACK;
                ST_HI_ACK:   if (ev.fall) state_n = ST_WAIT;
                ST_SYNC_ACK: if (ev.fall) state_n = ST_WAIT;
                default:     state_n = ST_IDLE;
            endcase
        end
    end

    // bit shifter and captured fields
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg      <= '0;
            bit_cnt    <= '0;
            lo_q       <= '0;
            sync_bit_q <= 1'b0;
        end else if (ev.start || ev.stop) begin
            bit_cnt <= '0;
        end else if (in_byte) begin
            if (ev.rise && !byte_done) begin
                shreg   <= {shreg[BYTE_W-2:0], sda_i};
                bit_cnt <= bit_cnt + 1'b1;
            end else if (ev.fall && byte_done) begin
                bit_cnt <= '0;
                if (state == ST_LO) begin
                    lo_q <= shreg;
                end
                if (state == ST_ADDR) begin
                    sync_bit_q <= shreg[0];
                end
            end
        end
    end

    // outputs
    always_comb begin
        sda_oe     = 1'b0;
        cmd_we     = 1'b0;
        word_we    = 1'b0;
        sync_load  = 1'b0;
        sync_clear = 1'b0;
        unique case (state)
            ST_ADDR_ACK, ST_LO_ACK: sda_oe = 1'b1;
            ST_CMD_ACK: begin
                sda_oe = 1'b1;
                cmd_we = ev.rise;
            end
            ST_HI_ACK: begin
                sda_oe  = 1'b1;
                word_we = ev.rise;
            end
            ST_SYNC_ACK: begin
                sda_oe     = 1'b1;
                sync_load  = ev.rise &  sync_bit_q;
                sync_clear = ev.rise & ~sync_bit_q;
            end
            default: sda_oe = 1'b0;
        endcase
    end

    assign word = {shreg[HI_W-1:0], lo_q};

    smb_dac_regs #(.DATA_W(DATA_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_we     (cmd_we),
        .cmd_sy     (shreg[SY_BIT]),
        .word_we    (word_we),
        .word       (word),
        .sync_load  (sync_load),
        .sync_clear (sync_clear),
        .out_q      (dac_code)
    );

    // R3: acknowledge begins only after a falling SCL
    a_r3_ack_starts_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> $past(ev.fall));

    // R3: acknowledge ends only on a falling SCL or a bus condition
    a_r3_ack_ends_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sda_oe) |-> $past(ev.fall || ev.start || ev.stop));

    // R1: STOP always releases the line
    a_r1_stop_releases: assert property (@(posedge clk) disable iff (!rst_n)
        ev.stop |=> !sda_oe);

    // R4/R5: register writes only occur while SCL is high
    a_r5_write_on_high: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_we || word_we || sync_load || sync_clear) |-> scl_i);

endmodule

// File: tb/smb_dac_rx_test.sv
module smb_dac_rx_test;

    localparam int         Q    = 3;
    localparam logic [6:0] OWN  = 7'h20;
    localparam logic [6:0] BCST = 7'b1111110;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic       sda_oe;
    logic [9:0] dac_code;
    wire        sda_bus = sda_m & ~sda_oe;

    int n_chk  = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    smb_dac_rx uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl_m),
        .sda_i    (sda_bus),
        .sda_oe   (sda_oe),
        .dac_code (dac_code)
    );

    task automatic wait_q();
        repeat (Q) @(negedge clk);
    endtask

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wait_q();
        scl_m = 1'b1; wait_q();
        sda_m = 1'b0; wait_q();
        scl_m = 1'b0; wait_q();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wait_q();
        scl_m = 1'b1; wait_q();
        sda_m = 1'b1; wait_q();
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        for (int i = 7; i > 7 - n; i--) begin
            sda_m = b[i]; wait_q();
            scl_m = 1'b1; wait_q(); wait_q();
            scl_m = 1'b0; wait_q();
        end
    endtask

    task automatic send_byte(input logic [7:0] b, input int exp_ack, input string req);
        send_bits(b, 8);
        sda_m = 1'b1; wait_q();
        chk({req, " ack level"}, int'(sda_oe), exp_ack);
        scl_m = 1'b1; wait_q(); wait_q();
        scl_m = 1'b0; wait_q();
        chk("R3 release after ack clock", int'(sda_oe), 0);
    endtask

    task automatic write_word(input logic [7:0] cmd, input logic [7:0] lo, input logic [7:0] hi);
        bus_start();
        send_byte({OWN, 1'b0}, 1, "R2 own address");
        send_byte(cmd, 1, "R4 command");
        send_byte(lo, 1, "R5 low byte");
        send_byte(hi, 1, "R5 high byte");
        bus_stop();
    endtask

    task automatic sync_cmd(input logic bitv);
        bus_start();
        send_byte({BCST, bitv}, 1, "R10 broadcast address");
        bus_stop();
    endtask

    task automatic t_reset();
        chk("R1 reset dac_code", int'(dac_code), 0);
        chk("R1 reset sda_oe", int'(sda_oe), 0);
    endtask

    task automatic t_direct_write();
        // R5/R6: SY=0, high byte bits 7:2 are junk
        write_word(8'h00, 8'hA5, 8'hFE);
        chk("R6 direct write", int'(dac_code), 10'h2A5);
        // R4: non-SY bits set are ignored
        write_word(8'h7F, 8'h3C, 8'h01);
        chk("R4 other command bits ignored", int'(dac_code), 10'h13C);
    endtask

    task automatic t_foreign();
        bus_start();
        send_byte({7'h21, 1'b0}, 0, "R2 other address");
        send_byte(8'h00, 0, "R2 no ack after foreign address");
        send_byte(8'h55, 0, "R2 still released");
        bus_stop();
        chk("R2 foreign write ignored", int'(dac_code), 10'h13C);
        bus_start();
        send_byte({OWN, 1'b1}, 0, "R2 read not acknowledged");
        bus_stop();
        chk("R1 stop leaves sda released", int'(sda_oe), 0);
    endtask

    task automatic t_sync_update();
        write_word(8'h80, 8'h55, 8'h01);
        chk("R7 held with SY set", int'(dac_code), 10'h13C);
        sync_cmd(1'b1);
        chk("R10 broadcast load", int'(dac_code), 10'h155);
    endtask

    task automatic t_interrupted();
        // input=0F0, output stays 155 with SY=1
        write_word(8'h80, 8'hF0, 8'h00);
        chk("R7 held again", int'(dac_code), 10'h155);
        // command SY=0 accepted, data cut off by STOP
        bus_start();
        send_byte({OWN, 1'b0}, 1, "R2 own address");
        send_byte(8'h00, 1, "R8 command");
        send_byte(8'h11, 1, "R8 low byte");
        send_bits(8'h03, 3);
        bus_stop();
        chk("R8 data dropped", int'(dac_code), 10'h155);
        sync_cmd(1'b1);
        chk("R8 R11 command kept so broadcast load ignored", int'(dac_code), 10'h155);
        // partial command with SY bit then repeated START
        bus_start();
        send_byte({OWN, 1'b0}, 1, "R2 own address");
        send_bits(8'h80, 4);
        bus_start();
        send_byte({OWN, 1'b0}, 1, "R1 address after repeated start");
        bus_stop();
        write_word(8'h00, 8'hC3, 8'h03);
        chk("R9 partial command discarded", int'(dac_code), 10'h3C3);
    endtask

    task automatic t_clear();
        write_word(8'h80, 8'h11, 8'h01);
        chk("R7 held before clear", int'(dac_code), 10'h3C3);
        sync_cmd(1'b0);
        chk("R12 output cleared", int'(dac_code), 0);
        // send-byte style command with SY=1, then load: input must be zero
        bus_start();
        send_byte({OWN, 1'b0}, 1, "R2 own address");
        send_byte(8'h80, 1, "R4 send byte command");
        bus_stop();
        sync_cmd(1'b1);
        chk("R12 input register cleared", int'(dac_code), 0);
        write_word(8'h00, 8'hAA, 8'h02);
        chk("R6 write after clear", int'(dac_code), 10'h2AA);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        t_reset();
        t_direct_write();
        t_foreign();
        t_sync_update();
        t_interrupted();
        t_clear();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule